// File: doc/BRIEF.md
# Gated Reciprocal Period Counter

This block times a fixed number of cycles of a slow, already-prescaled measurement signal against a fast reference clock. It runs entirely on the reference clock. The measurement signal enters through a synchronizer and a rising-edge detector. A small state machine opens a gate on the first rising edge after the host arms it. It closes the gate once eight further rising edges have arrived, so the window spans exactly eight periods of the measured signal. While the gate is open, a 21-bit register advances by one on every reference clock. The final value is therefore eight times the measured period, expressed in reference cycles.

The host drives a single control line. While `count_reset` is high, the block is held cleared: the count is zero, the gate is shut and the flags are low. When the line drops, the block arms itself. When the gate closes, the block asserts `prescale_hold` so that the upstream divider stops, and it raises `done` to show that `count_value` may be read. Both outputs stay high and the count stays frozen until the next `count_reset`.

The state machine has four states. CLEAR is entered from any state while `count_reset` is high. CLEAR goes to ARMED when `count_reset` is low. ARMED goes to GATING on a synchronized rising edge. GATING goes to DONE on the eighth rising edge counted inside the window. DONE is left only through CLEAR.

Top module: `period_gate_counter`

## Requirements
- R1: One clock after a cycle in which `count_reset` is high, `count_value` is 0 and `gate_open`, `done`, `prescale_hold` and `overflow` are all 0.
- R2: After `count_reset` falls, the first rising edge of `meas_in` opens the gate. A rise driven on `meas_in` shows on `gate_open` at the third rising clock edge after it, with the default two synchronizer stages.
- R3: The gate closes on the eighth rising edge of `meas_in` after the opening edge. For a steady period of P reference clocks, the final `count_value` is 8·P.
- R4: `count_value` rises by exactly one per clock while `gate_open` is high. While `gate_open` is low and `count_reset` is low, it does not change.
- R5: In the clock where the gate closes, `done` and `prescale_hold` both go high. They stay high until `count_reset`. `done` is never high while `gate_open` is high.
- R6: Once `done` is high, further edges on `meas_in` change neither `count_value` nor any flag.
- R7: When `count_value` is all ones and the gate is still open, it stays at all ones and `overflow` goes high. `overflow` stays high until `count_reset`.
- R8: Rising edges of `meas_in` that arrive while `count_reset` is high do not open the gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; also the counted clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_reset | input | 1 | Host clear; high holds the block cleared, low arms it |
| meas_in | input | 1 | Prescaled measurement signal, asynchronous |
| gate_open | output | 1 | High while the reference count is enabled |
| prescale_hold | output | 1 | Freezes the upstream prescaler once the window is closed |
| done | output | 1 | Measurement complete; count may be read |
| overflow | output | 1 | Count saturated at all ones during this window |
| count_value | output | COUNT_W (21) | Reference cycles counted inside the window |

## Verification
The assertions assume that `count_reset` is driven synchronously to `clk`. They also assume that `meas_in` stays at each level for several reference cycles, so that the synchronizer never drops an edge. The bench therefore drives every input half a clock away from the active edge. It uses measured periods of at least ten reference clocks, with equal high and low halves, and keeps `meas_in` low whenever it releases `count_reset`. Saturation is reached on a second instance built with an eight-bit counter. That instance shares the stimulus, so a period longer than 31 clocks drives it past all ones.

// File: rtl/gate_pkg.sv
package gate_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR  = 2'd0,
        ST_ARMED  = 2'd1,
        ST_GATING = 2'd2,
        ST_DONE   = 2'd3
    } gate_state_t;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= {sync_q[STAGES-2:0], din};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
    import gate_pkg::*;
#(
    parameter int GATE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic edge_rise,
    output logic gate_en,
    output logic finished
);

    localparam int CW = $clog2(GATE_CYCLES + 1);
    localparam logic [CW-1:0] LAST_EDGE = CW'(GATE_CYCLES - 1);

    gate_state_t state_q, state_d;
    logic [CW-1:0] edges_q;

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_CLEAR;
        end else begin
            unique case (state_q)
                ST_CLEAR:  state_d = ST_ARMED;
                ST_ARMED:  if (edge_rise) state_d = ST_GATING;
                ST_GATING: if (edge_rise && edges_q == LAST_EDGE) state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            edges_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != ST_GATING) begin
                edges_q <= '0;
            end else if (state_q == ST_GATING && edge_rise) begin
                edges_q <= edges_q + 1'b1;
            end
        end
    end

    always_comb begin
        gate_en  = 1'b0;
        finished = 1'b0;
        unique case (state_q)
            ST_CLEAR:  ;
            ST_ARMED:  ;
            ST_GATING: gate_en  = 1'b1;
            ST_DONE:   finished = 1'b1;
        endcase
    end

endmodule

// File: rtl/ref_counter.sv
module ref_counter #(
    parameter int WIDTH = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    output logic [WIDTH-1:0] value,
    output logic             saturated
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value     <= '0;
            saturated <= 1'b0;
        end else if (clear) begin
            value     <= '0;
            saturated <= 1'b0;
        end else if (enable) begin
            if (value == ALL_ONES) begin
                saturated <= 1'b1;
            end else begin
                value <= value + 1'b1;
            end
        end
    end

endmodule

// File: rtl/period_gate_counter.sv
module period_gate_counter #(
    parameter int COUNT_W     = 21,
    parameter int GATE_CYCLES = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_reset,
    input  logic               meas_in,
    output logic               gate_open,
    output logic               prescale_hold,
    output logic               done,
    output logic               overflow,
    output logic [COUNT_W-1:0] count_value
);

    logic meas_rise;
    logic gate_en;
    logic finished;

    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (meas_in),
        .rise (meas_rise)
    );

    gate_fsm #(.GATE_CYCLES(GATE_CYCLES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (count_reset),
        .edge_rise(meas_rise),
        .gate_en  (gate_en),
        .finished (finished)
    );

    ref_counter #(.WIDTH(COUNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (count_reset),
        .enable   (gate_en),
        .value    (count_value),
        .saturated(overflow)
    );

    assign gate_open     = gate_en;
    assign done          = finished;
    assign prescale_hold = finished;

endmodule

// File: rtl/period_gate_counter_chk.sv
module period_gate_counter_chk #(
    parameter int COUNT_W = 21
) (
    input logic               clk,
    input logic               rst_n,
    input logic               count_reset,
    input logic               gate_open,
    input logic               prescale_hold,
    input logic               done,
    input logic               overflow,
    input logic [COUNT_W-1:0] count_value
);

    localparam logic [COUNT_W-1:0] TOP = '1;

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        count_reset |=> (count_value == '0) && !gate_open && !done && !prescale_hold && !overflow); // R1

    AST_GATE_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && !count_reset) |=> (gate_open || done)); // R3

    AST_GATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_open && !count_reset && count_value != TOP) |=> count_value == $past(count_value) + 1'b1); // R4

    AST_SHUT_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_open && !count_reset) |=> $stable(count_value)); // R4

    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_open && done) && (done == prescale_hold)); // R5

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !count_reset) |=> done && $stable(count_value) && $stable(overflow)); // R6

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_value == TOP && !count_reset) |=> count_value == TOP); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !count_reset) |=> overflow); // R7

endmodule

bind period_gate_counter period_gate_counter_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .count_reset  (count_reset),
    .gate_open    (gate_open),
    .prescale_hold(prescale_hold),
    .done         (done),
    .overflow     (overflow),
    .count_value  (count_value)
);

// File: tb/test_period_gate_counter.sv
`timescale 1ns/1ps
module test_period_gate_counter;

    localparam int W  = 21;
    localparam int WS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic count_reset = 1'b0;
    logic meas_in = 1'b0;

    logic          gate_open, prescale_hold, done, overflow;
    logic [W-1:0]  count_value;
    logic          s_gate, s_hold, s_done, s_ovf;
    logic [WS-1:0] s_count;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    period_gate_counter #(.COUNT_W(W)) i_period_gate_counter (
        .clk(clk), .rst_n(rst_n), .count_reset(count_reset), .meas_in(meas_in),
        .gate_open(gate_open), .prescale_hold(prescale_hold), .done(done),
        .overflow(overflow), .count_value(count_value)
    );

    period_gate_counter #(.COUNT_W(WS)) i_period_gate_counter_small (
        .clk(clk), .rst_n(rst_n), .count_reset(count_reset), .meas_in(meas_in),
        .gate_open(s_gate), .prescale_hold(s_hold), .done(s_done),
        .overflow(s_ovf), .count_value(s_count)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic periods(input int p, input int n);
        for (int i = 0; i < n; i++) begin
            meas_in = 1'b0;
            cycles(p / 2);
            meas_in = 1'b1;
            cycles(p / 2);
        end
        meas_in = 1'b0;
    endtask

    task automatic clear_block();
        meas_in = 1'b0;
        count_reset = 1'b1;
        cycles(2);
        count_reset = 1'b0;
        cycles(2);
    endtask

    task automatic t_reset_state();
        check("R1", "count after rst", count_value, 0);
        check("R1", "flags after rst", {gate_open, done, prescale_hold, overflow}, 0);
    endtask

    task automatic t_open_latency();
        clear_block();
        meas_in = 1'b1;
        cycles(2);
        check("R2", "gate before third edge", gate_open, 0);
        cycles(1);
        check("R2", "gate at third edge", gate_open, 1);
        cycles(10);
        meas_in = 1'b0;
        cycles(10);
        check("R4", "count advancing in window", count_value, 20);
        clear_block();
        check("R1", "count after clear", count_value, 0);
        check("R1", "gate after clear", gate_open, 0);
    endtask

    task automatic t_measure(input int p);
        longint exp_small;
        logic [W-1:0] held;
        clear_block();
        cycles(3);
        check("R4", "count idle armed", count_value, 0);
        periods(p, 4);
        check("R3", "gate open mid window", gate_open, 1);
        periods(p, 5);
        cycles(6);
        check("R3", "count 8*P", count_value, 8 * p);
        check("R5", "done", done, 1);
        check("R5", "prescale_hold", prescale_hold, 1);
        check("R5", "gate closed", gate_open, 0);
        exp_small = (8 * p > 255) ? 255 : 8 * p;
        check("R7", "small count", s_count, exp_small);
        check("R7", "small overflow", s_ovf, (8 * p > 255) ? 1 : 0);
        check("R7", "wide overflow", overflow, 0);
        held = count_value;
        periods(p, 3);
        cycles(6);
        check("R6", "count frozen after done", count_value, held);
        check("R6", "done kept", done, 1);
        check("R6", "gate stays shut", gate_open, 0);
        count_reset = 1'b1;
        cycles(1);
        check("R1", "count cleared", count_value, 0);
        check("R1", "flags cleared", {done, prescale_hold, overflow, s_ovf}, 0);
        count_reset = 1'b0;
        cycles(2);
    endtask

    task automatic t_edges_in_reset();
        count_reset = 1'b1;
        periods(12, 4);
        cycles(5);
        check("R8", "gate under reset", gate_open, 0);
        check("R8", "count under reset", count_value, 0);
        check("R8", "done under reset", done, 0);
        count_reset = 1'b0;
        cycles(4);
        check("R8", "armed, no edge yet", gate_open, 0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset_state();
        t_open_latency();
        t_measure(10);
        t_measure(24);
        t_measure(40);
        t_edges_in_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule